// File: doc/BRIEF.md
# Port-Pin Level Interrupt Capture

This block turns a group of general-purpose input pins into latched interrupt requests. Every pin has three programmable settings: an active level, an enable bit and a request flag. Each pin passes through a two-flop synchronizer. It is then qualified against a machine-cycle strobe, so that only a level held for a whole machine cycle sets its flag. A set flag stays raised toward the interrupt controller until software clears it or the pin is disabled.

During power-down there is no machine-cycle strobe. In that state, any enabled pin at its active level drives a wake-up output directly. Software writes the polarity and enable registers through write strobes and clears flags with a per-bit clear mask.

Top module: `pin_irq_capture`

## Requirements
- R1: After reset, all polarity bits, enable bits and flags are zero, and irq_o and wake_o are low.
- R2: Each pin has its own polarity bit. Bit value 0 makes that pin active high and 1 makes it active low. The synchronized level is compared with this bit.
- R3: A pin's flag is set on an edge where mc_tick_i is high only if the synchronized pin was active at the previous strobe edge and at every clock since then. A level shorter than one machine cycle sets no flag. With the bench's 4-clock machine cycle, a pin made active just after a strobe raises its flag at the end of the second machine cycle.
- R4: A flag is set only while its enable bit is 1. A pin held active while disabled leaves its flag at 0.
- R5: A set flag stays set after the pin returns to its inactive level. It stays set until a clear or a disable removes it.
- R6: A 1 in bit n of flag_clr_i clears flag n on that clock edge. If the set condition for the same bit occurs on the same edge, the flag stays set.
- R7: Writing an enable value with bit n at 0 clears flag n on the edge of the write.
- R8: wake_o is high exactly when pd_i is high and at least one enabled pin's synchronized level is active. This path needs no strobe, and a pin change reaches it after two clock edges.
- R9: irq_o[n] carries flag n. A flag bit rises only on an edge where mc_tick_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Raw pin levels (asynchronous) |
| mc_tick_i | input | 1 | One-clock strobe marking the end of each machine cycle |
| pol_we_i | input | 1 | Polarity register write strobe |
| pol_wdata_i | input | NPINS | Polarity write data: 1 selects active low |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | NPINS | Enable write data |
| flag_clr_i | input | NPINS | Per-bit flag clear mask, one clock wide |
| pd_i | input | 1 | Power-down indication |
| irq_o | output | NPINS | Latched request flags to the interrupt controller |
| wake_o | output | 1 | Wake-up request during power-down |

## Verification
The embedded assertions check the flag bookkeeping on every cycle. A flag rises only on a strobe edge and only for a bit that was enabled. A flag falls only when a clear or an enable write occurred. After an enable write, no disabled bit holds a flag, and wake_o never rises with all enables at zero. The bench scenarios cover what depends on the timing of the pin's history. These are the one-machine-cycle qualification, the rejection of a short pulse, per-pin polarity over several mixed patterns, the set-over-clear priority, and the two-edge latency of the wake path with no strobe running.

// File: rtl/pin_irq_capture.sv
module pin_irq_capture #(
  parameter int NPINS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             mc_tick_i,
  input  logic             pol_we_i,
  input  logic [NPINS-1:0] pol_wdata_i,
  input  logic             en_we_i,
  input  logic [NPINS-1:0] en_wdata_i,
  input  logic [NPINS-1:0] flag_clr_i,
  input  logic             pd_i,
  output logic [NPINS-1:0] irq_o,
  output logic             wake_o
);

  logic [NPINS-1:0] sync1_q, sync2_q;
  logic [NPINS-1:0] pol_q, en_q, held_q, flag_q;
  logic [NPINS-1:0] active, set_hit, en_next;

  assign active  = sync2_q ^ pol_q;
  assign set_hit = {NPINS{mc_tick_i}} & held_q & active & en_q;
  assign en_next = en_we_i ? en_wdata_i : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      pol_q   <= '0;
      en_q    <= '0;
      held_q  <= '0;
      flag_q  <= '0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      if (pol_we_i) pol_q <= pol_wdata_i;
      en_q    <= en_next;
      held_q  <= mc_tick_i ? active : (held_q & active);
      flag_q  <= ((flag_q & ~flag_clr_i) | set_hit) & en_next;
    end
  end

  assign irq_o  = flag_q;
  assign wake_o = pd_i & |(en_q & active);

  a_r9_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~$past(irq_o)) != '0) |-> $past(mc_tick_i));

  a_r4_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~$past(irq_o) & ~$past(en_q)) == '0);

  a_r5_fall_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ((~irq_o & $past(irq_o)) != '0) |-> ($past(en_we_i) || ($past(flag_clr_i) != '0)));

  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    en_we_i |=> ((irq_o & ~$past(en_wdata_i)) == '0));

  a_r8_wake_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (en_q != '0));

endmodule

// File: tb/pin_irq_capture_bench.sv
`timescale 1ns/1ps
module pin_irq_capture_bench;
  localparam int N = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pin = '0, pol_wd = '0, en_wd = '0, clr = '0;
  logic tick = 1'b0, pol_we = 1'b0, en_we = 1'b0, pd = 1'b0;
  logic [N-1:0] irq;
  logic wake;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pin_irq_capture #(.NPINS(N)) u_pin_irq_capture (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .mc_tick_i(tick),
    .pol_we_i(pol_we), .pol_wdata_i(pol_wd), .en_we_i(en_we), .en_wdata_i(en_wd),
    .flag_clr_i(clr), .pd_i(pd), .irq_o(irq), .wake_o(wake));

  // {pol, en, pin, expected irq}
  localparam logic [4*N-1:0] VEC [4] = '{
    {7'h00, 7'h7F, 7'h55, 7'h55},
    {7'h7F, 7'h7F, 7'h55, 7'h2A},
    {7'h0F, 7'h33, 7'h00, 7'h03},
    {7'h70, 7'h7F, 7'h70, 7'h00}
  };

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clk1();
    @(posedge clk); #1;
  endtask

  task automatic mcyc(input logic [N-1:0] clr_at_tick);
    for (int i = 0; i < 4; i++) begin
      tick = (i == 3);
      clr  = (i == 3) ? clr_at_tick : '0;
      clk1();
    end
    tick = 1'b0; clr = '0;
  endtask

  task automatic wr_en(input logic [N-1:0] v);
    en_we = 1'b1; en_wd = v; clk1(); en_we = 1'b0;
  endtask

  task automatic wr_pol(input logic [N-1:0] v);
    pol_we = 1'b1; pol_wd = v; clk1(); pol_we = 1'b0;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    clk1(); clk1();
    chk("R1 irq after reset", irq, '0);
    chk("R1 wake after reset", {6'b0, wake}, '0);
    rst_n = 1'b1;
    pin = 7'h7F; pd = 1'b1;
    clk1(); clk1(); clk1();
    chk("R1 enables zero so no wake", {6'b0, wake}, '0);
    pd = 1'b0; pin = '0;

    // Vector table: R2 polarity per pin, R4 enable masking
    foreach (VEC[k]) begin
      wr_en('0);
      wr_pol(VEC[k][4*N-1 -: N]);
      pin = VEC[k][2*N-1 -: N];
      mcyc('0); mcyc('0);
      wr_en(VEC[k][3*N-1 -: N]);
      mcyc('0); mcyc('0);
      chk("R2/R4 vector irq", irq, VEC[k][N-1:0]);
      pd = 1'b1; #0.1;
      chk("R8 vector wake", {6'b0, wake}, {6'b0, VEC[k][N-1:0] != '0});
      pd = 1'b0;
    end

    // Directed: bit 0 active high, only bit 0 enabled
    wr_en('0); wr_pol('0); pin = '0; mcyc('0); mcyc('0);
    wr_en(7'h01);
    pin = 7'h01;
    mcyc('0);
    chk("R3 one machine cycle not yet accepted", irq, '0);
    mcyc('0);
    chk("R3 accepted after full machine cycle", irq, 7'h01);

    pin = '0; mcyc('0); mcyc('0);
    chk("R5 flag sticky after pin inactive", irq, 7'h01);
    clr = 7'h01; clk1(); clr = '0;
    chk("R6 software clear", irq, '0);
    mcyc('0); mcyc('0);
    chk("R5 stays clear with pin inactive", irq, '0);

    // Short pulse rejected
    pin = 7'h01; mcyc('0); pin = '0; mcyc('0); mcyc('0);
    chk("R3 short pulse rejected", irq, '0);

    // Set wins over clear on same edge
    pin = 7'h01; mcyc('0); mcyc('0);
    chk("R3 set before priority test", irq, 7'h01);
    mcyc(7'h01);
    chk("R6 set wins over simultaneous clear", irq, 7'h01);
    clr = 7'h01; clk1(); clr = '0;
    chk("R6 clear off-strobe while pin active", irq, '0);
    tick = 1'b1; clk1(); tick = 1'b0;
    chk("R9 re-set on strobe with held level", irq, 7'h01);

    // Disable clears, stays clear
    wr_en('0);
    chk("R7 disable clears flag", irq, '0);
    mcyc('0); mcyc('0);
    chk("R4 no set while disabled", irq, '0);

    // Wake path without strobe
    wr_en(7'h01); pin = '0; pd = 1'b1; clk1(); clk1();
    chk("R8 wake low with pin inactive", {6'b0, wake}, '0);
    pin = 7'h01; clk1();
    chk("R8 wake not after one edge", {6'b0, wake}, '0);
    clk1();
    chk("R8 wake after two edges no strobe", {6'b0, wake}, 7'h01);
    pd = 1'b0; #0.1;
    chk("R8 wake low when not powered down", {6'b0, wake}, '0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule